// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block holds the software-visible configuration and status state of an Ethernet MAC. A processor reaches it through a plain 32-bit register bus made of a request strobe, a write flag, an access-size code, a byte address, write data, combinational read data and an error response. The block hands its control fields (operating mode, system control, station address and multicast hash) to the MAC datapath. In return, the datapath sends one-cycle status-set vectors and counter-increment pulses.

Each register follows its own write rule. Some are plain storage. Some clear bits where a 1 is written, either over the whole word or only over a fixed subset of bits. The frame status words cannot be written at all. The counter-control register carries a self-clearing command that zeroes every statistics counter. A separate address window for precise-time registers answers without error but holds nothing. A single interrupt line combines each sticky or pending register with its enable register.

Top module: `emac_csr`

## Requirements
- R1: An access is legal only with `bus_size` = 2 (32-bit) and `bus_addr[1:0]` = 0. A request that breaks this sets `bus_err` with `bus_err_kind` = 0, even when its address is also unmapped. A legal-size request to an unmapped word sets `bus_err` with `bus_err_kind` = 1. An errored access changes no state, and `bus_rdata` is 0 whenever there is no error-free read.
- R2: After reset the following values read back: station address low (0x004) 0xFFFFFFFF, station address high (0x008) 0x0000FFFF, both VLAN tag registers (0x020, 0x024) 0x0000FFFF, system control (0x050) 0x00003F00 and counter control (0x070) 0x0000000A. Every other register and counter reads 0.
- R3: The following registers are plain read/write: mode (0x000), station address (0x004, 0x008), hash (0x00C, 0x010), management address and data (0x014, 0x018), flow control (0x01C), VLAN tags, wake-up filters (0x02C to 0x048), system control and the four enable registers (0x060, 0x06C, 0x078, 0x080). `ctl_mode`, `ctl_sysctl`, `ctl_mac_addr` (= {addr-high[15:0], addr-low}) and `ctl_hash` (= {hash-high, hash-low}) follow these registers.
- R4: Writing mode (0x000) with bit 0 (receive enable) going from 0 to 1 clears bit 12 (receive done) of RX status (0x058). Writing mode with bit 1 (transmit enable) going from 0 to 1 clears bit 0 (transmit done) of TX status (0x064). Writing a 1 to an enable bit that is already 1 clears nothing.
- R5: Wake-up control (0x028) clears, where a 1 is written, only the bits in mask 0x00000F20. Its remaining bits take the written value.
- R6: System status (0x054) clears, where a 1 is written, the bits in mask 0x000000E1. Writes leave its other bits unchanged.
- R7: RX sticky (0x05C), TX sticky (0x068), RX counter-interrupt status (0x074) and TX counter-interrupt status (0x07C) clear every bit where a 1 is written.
- R8: Writes to RX status (0x058) and TX status (0x064) have no effect.
- R9: A write to counter control (0x070) with bit 0 set zeroes every RX and TX counter in the next cycle, overriding any increment in that cycle. Bit 0 always reads 0, and the other bits store the written value.
- R10: Word addresses 0x0A0 to 0x0FC accept reads and writes without error, store nothing and read 0.
- R11: The set vectors `rx_set_i`, `tx_set_i`, `sys_set_i`, `wake_set_i`, `crx_irq_set_i` and `ctx_irq_set_i` are ORed into their registers at the next clock edge. `rx_set_i` and `tx_set_i` go into both the status and the sticky register. A set bit wins over a clear request on the same bit in the same cycle.
- R12: `irq` is 1 exactly when some bit is set both in a sticky or pending register and in its enable register. The four pairs are 0x05C/0x060, 0x068/0x06C, 0x074/0x078 and 0x07C/0x080.
- R13: RX counter k is at 0x100+4k and TX counter k is at 0x180+4k. A counter adds 1 in each cycle its increment bit is high and wraps at 2^32. A bus write loads a counter and takes priority over its increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code; 2 = 32-bit |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Error response |
| bus_err_kind | output | 1 | 0 = size/alignment, 1 = unmapped |
| rx_set_i | input | 32 | Set bits for RX status and RX sticky |
| tx_set_i | input | 32 | Set bits for TX status and TX sticky |
| sys_set_i | input | 32 | Set bits for system status |
| wake_set_i | input | 32 | Set bits for wake-up control |
| crx_irq_set_i | input | 32 | Set bits for RX counter-interrupt status |
| ctx_irq_set_i | input | 32 | Set bits for TX counter-interrupt status |
| rxc_inc_i | input | N_RXC | RX counter increment pulses |
| txc_inc_i | input | N_TXC | TX counter increment pulses |
| ctl_mode | output | 32 | Operating mode register |
| ctl_sysctl | output | 32 | System control register |
| ctl_mac_addr | output | 48 | Station address |
| ctl_hash | output | 64 | Multicast hash |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that every input is driven to a known value in every cycle, including during reset. They also assume that set vectors and increment pulses come from the datapath as plain per-cycle levels, with no handshake. The bench changes all inputs only on falling edges and holds them steady up to the next rising edge. Between accesses it drives the set vectors and increment pulses to zero. It raises them only in chosen cycles, sometimes in the same cycle as a conflicting bus write, so that the precedence rules are exercised on purpose rather than by chance.

// File: rtl/emac_csr_pkg.sv
package emac_csr_pkg;

  localparam int DW        = 32;
  localparam int SLOTS     = 64;   // word slots reserved for control/status
  localparam int SLOT_W    = 6;

  // word indices
  localparam int W_MODE    = 0;
  localparam int W_ADR_LO  = 1;
  localparam int W_ADR_HI  = 2;
  localparam int W_HASH_LO = 3;
  localparam int W_HASH_HI = 4;
  localparam int W_VLAN_A  = 8;
  localparam int W_VLAN_B  = 9;
  localparam int W_WAKE    = 10;
  localparam int W_WF_LAST = 18;
  localparam int W_SYSCTL  = 20;
  localparam int W_SYSSTAT = 21;
  localparam int W_RXSTAT  = 22;
  localparam int W_RXSTKY  = 23;
  localparam int W_RXIEN   = 24;
  localparam int W_TXSTAT  = 25;
  localparam int W_TXSTKY  = 26;
  localparam int W_TXIEN   = 27;
  localparam int W_CNTCTL  = 28;
  localparam int W_CRXIST  = 29;
  localparam int W_CRXIEN  = 30;
  localparam int W_CTXIST  = 31;
  localparam int W_CTXIEN  = 32;
  localparam int W_TIME_LO = 40;
  localparam int W_TIME_HI = 63;
  localparam int W_RXC     = 64;
  localparam int W_TXC     = 96;
  localparam int CNT_IDX_W = 5;

  // bit positions the behaviour depends on
  localparam int MODE_RXEN = 0;
  localparam int MODE_TXEN = 1;
  localparam int RX_DONE   = 12;
  localparam int TX_DONE   = 0;
  localparam int CNT_WIPE  = 0;

  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic {ERR_SIZE = 1'b0, ERR_MAP = 1'b1} err_kind_e;

  function automatic logic slot_present(input int w);
    return (w >= W_MODE && w <= W_WF_LAST) || (w >= W_SYSCTL && w <= W_CTXIEN);
  endfunction

  function automatic logic [DW-1:0] slot_reset(input int w);
    case (w)
      W_ADR_LO:                     return 32'hFFFF_FFFF;
      W_ADR_HI, W_VLAN_A, W_VLAN_B: return 32'h0000_FFFF;
      W_SYSCTL:                     return 32'h0000_3F00;
      W_CNTCTL:                     return 32'h0000_000A;
      default:                      return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_w1c(input int w);
    case (w)
      W_WAKE:                                   return 32'h0000_0F20;
      W_SYSSTAT:                                return 32'h0000_00E1;
      W_RXSTKY, W_TXSTKY, W_CRXIST, W_CTXIST:   return 32'hFFFF_FFFF;
      default:                                  return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_wrmask(input int w);
    case (w)
      W_WAKE:                                   return ~32'h0000_0F20;
      W_SYSSTAT, W_RXSTAT, W_TXSTAT,
      W_RXSTKY, W_TXSTKY, W_CRXIST, W_CTXIST:   return '0;
      W_CNTCTL:                                 return 32'hFFFF_FFFE;
      default:                                  return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/emac_csr_rst_sync.sv
module emac_csr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/emac_csr_decode.sv
module emac_csr_decode
  import emac_csr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int N_RXC  = 24,
  parameter int N_TXC  = 23
) (
  input  logic              req_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              err_o,
  output logic              err_kind_o,
  output logic              slot_hit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              time_hit_o,
  output logic              rxc_hit_o,
  output logic              txc_hit_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic legal_sz, is_slot, is_time, is_rxc, is_txc;
  int   w;

  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    w        = int'(word);
    legal_sz = (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00);
    is_slot  = (w < SLOTS) && slot_present(w);
    is_time  = (w >= W_TIME_LO) && (w <= W_TIME_HI);
    is_rxc   = (w >= W_RXC) && (w < W_RXC + N_RXC);
    is_txc   = (w >= W_TXC) && (w < W_TXC + N_TXC);
    err_o      = req_i && !(legal_sz && (is_slot || is_time || is_rxc || is_txc));
    err_kind_o = (err_o && legal_sz) ? ERR_MAP : ERR_SIZE;
  end

  assign slot_hit_o = req_i && !err_o && is_slot;
  assign time_hit_o = req_i && !err_o && is_time;
  assign rxc_hit_o  = req_i && !err_o && is_rxc;
  assign txc_hit_o  = req_i && !err_o && is_txc;
  assign slot_o     = word[SLOT_W-1:0];
endmodule

// File: rtl/emac_csr_cell.sv
module emac_csr_cell #(
  parameter int          DW     = 32,
  parameter logic [31:0] RESET  = '0,
  parameter logic [31:0] W1C    = '0,
  parameter logic [31:0] WRMASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] base, nxt;
  logic          en;

  always_comb begin
    base = q_o;
    if (wr_i) base = (q_o & ~WRMASK[DW-1:0] & ~(wdata_i & W1C[DW-1:0]))
                   | (wdata_i & WRMASK[DW-1:0]);
    nxt = (base & ~clr_i) | set_i;
    en  = wr_i || (|set_i) || (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= RESET[DW-1:0];
    else if (en) q_o <= nxt;
  end
endmodule

// File: rtl/emac_csr_counters.sv
module emac_csr_counters #(
  parameter int N     = 24,
  parameter int W     = 32,
  parameter int IDX_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        inc_i,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [W-1:0]        wdata_i,
  input  logic                wipe_i,
  output logic [N-1:0][W-1:0] cnt_o
);
  for (genvar k = 0; k < N; k++) begin : g_cnt
    logic [W-1:0] nxt;
    logic         en;
    logic         hit;

    assign hit = wr_i && (idx_i == IDX_W'(k));

    always_comb begin
      en  = wipe_i || hit || inc_i[k];
      nxt = cnt_o[k] + W'(1);
      if (hit)    nxt = wdata_i;
      if (wipe_i) nxt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_o[k] <= '0;
      else if (en) cnt_o[k] <= nxt;
    end
  end
endmodule

// File: rtl/emac_csr.sv
module emac_csr
  import emac_csr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int N_RXC  = 24,
  parameter int N_TXC  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              bus_err_kind,
  input  logic [31:0]       rx_set_i,
  input  logic [31:0]       tx_set_i,
  input  logic [31:0]       sys_set_i,
  input  logic [31:0]       wake_set_i,
  input  logic [31:0]       crx_irq_set_i,
  input  logic [31:0]       ctx_irq_set_i,
  input  logic [N_RXC-1:0]  rxc_inc_i,
  input  logic [N_TXC-1:0]  txc_inc_i,
  output logic [31:0]       ctl_mode,
  output logic [31:0]       ctl_sysctl,
  output logic [47:0]       ctl_mac_addr,
  output logic [63:0]       ctl_hash,
  output logic              irq
);
  logic rst_n_s;
  logic slot_hit, time_hit, rxc_hit, txc_hit, wr_ok;
  logic [SLOT_W-1:0] slot;
  logic [DW-1:0] q     [SLOTS];
  logic [DW-1:0] set_v [SLOTS];
  logic [DW-1:0] clr_v [SLOTS];
  logic [N_RXC-1:0][DW-1:0] rxc;
  logic [N_TXC-1:0][DW-1:0] txc;
  logic rx_rise, tx_rise, wipe, mode_wr;
  logic [DW-1:0] rx_stat_q;
  logic cnt_any_nz;

  emac_csr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  emac_csr_decode #(.ADDR_W(ADDR_W), .N_RXC(N_RXC), .N_TXC(N_TXC)) u_dec (
    .req_i(bus_req), .size_i(bus_size), .addr_i(bus_addr),
    .err_o(bus_err), .err_kind_o(bus_err_kind),
    .slot_hit_o(slot_hit), .slot_o(slot), .time_hit_o(time_hit),
    .rxc_hit_o(rxc_hit), .txc_hit_o(txc_hit)
  );

  assign wr_ok   = bus_wr && slot_hit;
  assign mode_wr = wr_ok && (slot == SLOT_W'(W_MODE));
  assign rx_rise = mode_wr && !q[W_MODE][MODE_RXEN] && bus_wdata[MODE_RXEN];
  assign tx_rise = mode_wr && !q[W_MODE][MODE_TXEN] && bus_wdata[MODE_TXEN];
  assign wipe    = wr_ok && (slot == SLOT_W'(W_CNTCTL)) && bus_wdata[CNT_WIPE];

  // status-set and edge-clear routing
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      set_v[i] = '0;
      clr_v[i] = '0;
    end
    set_v[W_RXSTAT]  = rx_set_i;
    set_v[W_RXSTKY]  = rx_set_i;
    set_v[W_TXSTAT]  = tx_set_i;
    set_v[W_TXSTKY]  = tx_set_i;
    set_v[W_SYSSTAT] = sys_set_i;
    set_v[W_WAKE]    = wake_set_i;
    set_v[W_CRXIST]  = crx_irq_set_i;
    set_v[W_CTXIST]  = ctx_irq_set_i;
    clr_v[W_RXSTAT][RX_DONE] = rx_rise;
    clr_v[W_TXSTAT][TX_DONE] = tx_rise;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (slot_present(i)) begin : g_cell
      logic cell_wr;
      assign cell_wr = wr_ok && (slot == SLOT_W'(i));
      emac_csr_cell #(
        .DW(DW), .RESET(slot_reset(i)), .W1C(slot_w1c(i)), .WRMASK(slot_wrmask(i))
      ) u_cell (
        .clk(clk), .rst_n(rst_n_s), .wr_i(cell_wr), .wdata_i(bus_wdata),
        .set_i(set_v[i]), .clr_i(clr_v[i]), .q_o(q[i])
      );
    end else begin : g_hole
      assign q[i] = '0;
    end
  end

  emac_csr_counters #(.N(N_RXC), .W(DW), .IDX_W(CNT_IDX_W)) u_rxc (
    .clk(clk), .rst_n(rst_n_s), .inc_i(rxc_inc_i), .wr_i(bus_wr && rxc_hit),
    .idx_i(bus_addr[CNT_IDX_W+1:2]), .wdata_i(bus_wdata), .wipe_i(wipe), .cnt_o(rxc)
  );

  emac_csr_counters #(.N(N_TXC), .W(DW), .IDX_W(CNT_IDX_W)) u_txc (
    .clk(clk), .rst_n(rst_n_s), .inc_i(txc_inc_i), .wr_i(bus_wr && txc_hit),
    .idx_i(bus_addr[CNT_IDX_W+1:2]), .wdata_i(bus_wdata), .wipe_i(wipe), .cnt_o(txc)
  );

  // read path; the time window falls through to zero
  always_comb begin
    bus_rdata = '0;
    if (!bus_wr) begin
      if (slot_hit) bus_rdata = q[slot];
      for (int k = 0; k < N_RXC; k++)
        if (rxc_hit && bus_addr[CNT_IDX_W+1:2] == CNT_IDX_W'(k)) bus_rdata = rxc[k];
      for (int k = 0; k < N_TXC; k++)
        if (txc_hit && bus_addr[CNT_IDX_W+1:2] == CNT_IDX_W'(k)) bus_rdata = txc[k];
      if (time_hit) bus_rdata = '0;
    end
  end

  assign irq = (|(q[W_RXSTKY] & q[W_RXIEN])) | (|(q[W_TXSTKY] & q[W_TXIEN]))
             | (|(q[W_CRXIST] & q[W_CRXIEN])) | (|(q[W_CTXIST] & q[W_CTXIEN]));

  assign ctl_mode     = q[W_MODE];
  assign ctl_sysctl   = q[W_SYSCTL];
  assign ctl_mac_addr = {q[W_ADR_HI][15:0], q[W_ADR_LO]};
  assign ctl_hash     = {q[W_HASH_HI], q[W_HASH_LO]};
  assign rx_stat_q    = q[W_RXSTAT];
  assign cnt_any_nz   = (|rxc) | (|txc);
endmodule

// File: rtl/emac_csr_chk.sv
module emac_csr_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              bus_err_kind,
  input logic [31:0]       ctl_mode,
  input logic [31:0]       rx_set_i,
  input logic [31:0]       rx_stat,
  input logic              cnt_any_nz
);
  localparam logic [ADDR_W-1:0] A_MODE   = '0;
  localparam logic [ADDR_W-1:0] A_CNTCTL = ADDR_W'(32'h070);

  p_size_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (bus_size != 2'd2 || bus_addr[1:0] != 2'b00)) |-> (bus_err && !bus_err_kind));

  p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == 32'h0));

  p_err_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_err) |=> $stable(ctl_mode));

  p_rx_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && !bus_err && bus_addr == A_MODE && !ctl_mode[0]
     && bus_wdata[0] && !rx_set_i[12]) |=> !rx_stat[12]);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set_i != 32'h0) |=> ((rx_stat & $past(rx_set_i)) == $past(rx_set_i)));

  p_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && !bus_err && bus_addr == A_CNTCTL && bus_wdata[0]) |=> !cnt_any_nz);
endmodule

bind emac_csr emac_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_err_kind(bus_err_kind),
  .ctl_mode(ctl_mode), .rx_set_i(rx_set_i), .rx_stat(rx_stat_q),
  .cnt_any_nz(cnt_any_nz)
);

// File: tb/emac_csr_test.sv
module emac_csr_test;
  localparam int PERIOD = 10;
  localparam int AW = 10;
  localparam int NR = 24;
  localparam int NT = 23;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_req, bus_wr, bus_err, bus_err_kind, irq;
  logic [1:0] bus_size;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] rx_set_i, tx_set_i, sys_set_i, wake_set_i, crx_irq_set_i, ctx_irq_set_i;
  logic [NR-1:0] rxc_inc_i;
  logic [NT-1:0] txc_inc_i;
  logic [31:0] ctl_mode, ctl_sysctl;
  logic [47:0] ctl_mac_addr;
  logic [63:0] ctl_hash;

  int checks = 0;
  int bad = 0;

  // reference model state
  logic [31:0] m_reg [64];
  logic [31:0] m_rxc [NR];
  logic [31:0] m_txc [NT];

  always #(PERIOD/2) clk = ~clk;

  emac_csr #(.ADDR_W(AW), .N_RXC(NR), .N_TXC(NT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .bus_err_kind(bus_err_kind),
    .rx_set_i(rx_set_i), .tx_set_i(tx_set_i), .sys_set_i(sys_set_i),
    .wake_set_i(wake_set_i), .crx_irq_set_i(crx_irq_set_i), .ctx_irq_set_i(ctx_irq_set_i),
    .rxc_inc_i(rxc_inc_i), .txc_inc_i(txc_inc_i), .ctl_mode(ctl_mode),
    .ctl_sysctl(ctl_sysctl), .ctl_mac_addr(ctl_mac_addr), .ctl_hash(ctl_hash), .irq(irq)
  );

  function automatic bit word_mapped(int w);
    if (w <= 18) return 1;
    if (w >= 20 && w <= 32) return 1;
    if (w >= 40 && w <= 63) return 1;
    if (w >= 64 && w < 64 + NR) return 1;
    if (w >= 96 && w < 96 + NT) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_reg[i] = 32'h0;
    m_reg[1]  = 32'hFFFF_FFFF;
    m_reg[2]  = 32'h0000_FFFF;
    m_reg[8]  = 32'h0000_FFFF;
    m_reg[9]  = 32'h0000_FFFF;
    m_reg[20] = 32'h0000_3F00;
    m_reg[28] = 32'h0000_000A;
    for (int i = 0; i < NR; i++) m_rxc[i] = 32'h0;
    for (int i = 0; i < NT; i++) m_txc[i] = 32'h0;
  endtask

  task automatic clear_stim();
    bus_req = 0; bus_wr = 0; bus_size = 2'd2; bus_addr = '0; bus_wdata = '0;
    rx_set_i = '0; tx_set_i = '0; sys_set_i = '0; wake_set_i = '0;
    crx_irq_set_i = '0; ctx_irq_set_i = '0; rxc_inc_i = '0; txc_inc_i = '0;
  endtask

  // compare outputs, wait for the edge, advance the model, return to falling edge
  task automatic tick(string tag);
    logic [31:0] e_rd;
    logic e_err, e_kind, e_irq;
    bit legal;
    int w;
    logic [31:0] d, old;
    bit wipe;
    #(PERIOD/4);
    legal = (bus_size == 2'd2) && (bus_addr[1:0] == 2'b00);
    w = int'(bus_addr) >> 2;
    e_err = bus_req && !(legal && word_mapped(w));
    e_kind = e_err && legal;
    e_rd = 32'h0;
    if (bus_req && !bus_wr && !e_err) begin
      if (w <= 32) e_rd = m_reg[w];
      else if (w >= 64 && w < 64 + NR) e_rd = m_rxc[w-64];
      else if (w >= 96 && w < 96 + NT) e_rd = m_txc[w-96];
    end
    e_irq = |(m_reg[23] & m_reg[24]) || |(m_reg[26] & m_reg[27])
         || |(m_reg[29] & m_reg[30]) || |(m_reg[31] & m_reg[32]);
    checks++;
    if (bus_rdata !== e_rd || bus_err !== e_err || bus_err_kind !== e_kind || irq !== e_irq
        || ctl_mode !== m_reg[0] || ctl_sysctl !== m_reg[20]
        || ctl_mac_addr !== {m_reg[2][15:0], m_reg[1]} || ctl_hash !== {m_reg[4], m_reg[3]}) begin
      bad++;
      $display("FAIL %s t=%0t rdata=%h/%h err=%b/%b kind=%b/%b irq=%b/%b mode=%h/%h sysctl=%h/%h mac=%h/%h hash=%h/%h (actual/expected)",
        tag, $time, bus_rdata, e_rd, bus_err, e_err, bus_err_kind, e_kind, irq, e_irq,
        ctl_mode, m_reg[0], ctl_sysctl, m_reg[20], ctl_mac_addr, {m_reg[2][15:0], m_reg[1]},
        ctl_hash, {m_reg[4], m_reg[3]});
    end
    @(posedge clk);
    d = bus_wdata;
    wipe = 0;
    if (bus_req && bus_wr && !e_err) begin
      if (w == 0) begin
        old = m_reg[0];
        if (!old[0] && d[0]) m_reg[22][12] = 1'b0;
        if (!old[1] && d[1]) m_reg[25][0] = 1'b0;
        m_reg[0] = d;
      end else if (w == 10) m_reg[10] = (m_reg[10] & 32'hF20 & ~d) | (d & ~32'hF20);
      else if (w == 21) m_reg[21] = m_reg[21] & ~(d & 32'hE1);
      else if (w == 22 || w == 25) begin end
      else if (w == 23 || w == 26 || w == 29 || w == 31) m_reg[w] = m_reg[w] & ~d;
      else if (w == 28) begin m_reg[28] = d & ~32'h1; wipe = d[0]; end
      else if (w <= 32) m_reg[w] = d;
    end
    m_reg[22] |= rx_set_i;  m_reg[23] |= rx_set_i;
    m_reg[25] |= tx_set_i;  m_reg[26] |= tx_set_i;
    m_reg[21] |= sys_set_i; m_reg[10] |= wake_set_i;
    m_reg[29] |= crx_irq_set_i; m_reg[31] |= ctx_irq_set_i;
    for (int i = 0; i < NR; i++) begin
      if (wipe) m_rxc[i] = 0;
      else if (bus_req && bus_wr && !e_err && w == 64 + i) m_rxc[i] = d;
      else if (rxc_inc_i[i]) m_rxc[i] = m_rxc[i] + 1;
    end
    for (int i = 0; i < NT; i++) begin
      if (wipe) m_txc[i] = 0;
      else if (bus_req && bus_wr && !e_err && w == 96 + i) m_txc[i] = d;
      else if (txc_inc_i[i]) m_txc[i] = m_txc[i] + 1;
    end
    @(negedge clk);
    clear_stim();
  endtask

  task automatic wr(string tag, int a, logic [31:0] d);
    bus_req = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    tick(tag);
  endtask

  task automatic rd(string tag, int a);
    bus_req = 1; bus_wr = 0; bus_addr = AW'(a);
    tick(tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    clear_stim();
    model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 reset values
    tick("R2");
    rd("R2", 'h004); rd("R2", 'h008); rd("R2", 'h020); rd("R2", 'h024);
    rd("R2", 'h050); rd("R2", 'h070); rd("R2", 'h000); rd("R2", 'h100);

    // R3 plain storage and exported fields
    wr("R3", 'h00C, 32'hA5A5_0F0F); wr("R3", 'h010, 32'h1234_5678);
    rd("R3", 'h00C); rd("R3", 'h010);
    wr("R3", 'h004, 32'h1122_3344); wr("R3", 'h008, 32'hABCD_5566);
    rd("R3", 'h008);
    wr("R3", 'h02C, 32'hDEAD_BEEF); rd("R3", 'h02C);
    wr("R3", 'h050, 32'h0000_1234); rd("R3", 'h050);

    // R1 size and map errors
    bus_size = 2'd1; wr("R1", 'h00C, 32'h0);
    rd("R1", 'h00C);
    wr("R1", 'h04C, 32'hFFFF_FFFF);
    rd("R1", 'h04D);
    rd("R1", 'h200);
    bus_size = 2'd0; rd("R1", 'h3FC);
    bus_size = 2'd2; wr("R1", 'h3FE, 32'h3);

    // R11 set vectors into status and sticky
    rx_set_i = 32'h0000_1008; tick("R11");
    rd("R11", 'h058); rd("R11", 'h05C);

    // R4 enable rising edges
    wr("R4", 'h000, 32'h1); rd("R4", 'h058);
    rx_set_i = 32'h0000_1000; tick("R4");
    wr("R4", 'h000, 32'h1); rd("R4", 'h058);
    tx_set_i = 32'h0000_0001; tick("R4");
    wr("R4", 'h000, 32'h3); rd("R4", 'h064); rd("R4", 'h068);

    // R8 status words ignore writes
    wr("R8", 'h058, 32'hFFFF_FFFF); rd("R8", 'h058);
    wr("R8", 'h064, 32'h0); rd("R8", 'h068);

    // R7 full write-one-to-clear, R11 set beats clear
    wr("R7", 'h05C, 32'h8); rd("R7", 'h05C);
    rx_set_i = 32'h0000_1000; wr("R11", 'h05C, 32'h1000); rd("R11", 'h05C);
    crx_irq_set_i = 32'hF; tick("R7");
    wr("R7", 'h074, 32'h5); rd("R7", 'h074);
    ctx_irq_set_i = 32'h3; tick("R7");
    wr("R7", 'h07C, 32'hFFFF_FFFF); rd("R7", 'h07C);

    // R12 interrupt combination
    wr("R12", 'h060, 32'h1000); tick("R12");
    wr("R12", 'h05C, 32'h1000); tick("R12");
    wr("R12", 'h078, 32'h2); tick("R12");
    wr("R12", 'h074, 32'hA); tick("R12");
    tx_set_i = 32'h4; wr("R12", 'h06C, 32'h4); tick("R12");

    // R6 system status partial clear
    sys_set_i = 32'hFF; tick("R6");
    wr("R6", 'h054, 32'hFFFF_FFFF); rd("R6", 'h054);

    // R5 wake-up control partial clear
    wr("R5", 'h028, 32'hFFFF_FFFF); rd("R5", 'h028);
    wake_set_i = 32'h0000_0F20; tick("R5"); rd("R5", 'h028);
    wr("R5", 'h028, 32'h0000_0020); rd("R5", 'h028);

    // R13 counters
    repeat (3) begin rxc_inc_i = '1; tick("R13"); end
    txc_inc_i = NT'(1); tick("R13");
    rd("R13", 'h100); rd("R13", 'h104); rd("R13", 'h180); rd("R13", 'h184);
    rxc_inc_i = '1; wr("R13", 'h108, 32'h7); rd("R13", 'h108); rd("R13", 'h10C);
    wr("R13", 'h180 + 4*(NT-1), 32'hFFFF_FFFF);
    txc_inc_i = '1; tick("R13"); rd("R13", 'h180 + 4*(NT-1));

    // R9 counter wipe beats increments
    rxc_inc_i = '1; txc_inc_i = '1; wr("R9", 'h070, 32'h0000_000B);
    rd("R9", 'h100); rd("R9", 'h070); rd("R9", 'h180);

    // R10 time window
    wr("R10", 'h0A0, 32'h55); rd("R10", 'h0A0); rd("R10", 'h0FC);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule